// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier with Early Exit

This block multiplies two unsigned operands one partial product per clock cycle. A one-cycle `start_i` loads both operands. The block then works through the first operand (the multiplier) from its least significant bit upward. For each set bit, it adds the suitably shifted second operand (the multiplicand) into a double-width accumulator. The result appears on `product_o`, and `done_o` pulses for one cycle.

Latency depends on the data. Work stops as soon as the multiplier has no set bits left. If either operand is zero, the block finishes at once with a zero product. A caller waits for `done_o` and must not overlap requests. A start that arrives while the block is busy is dropped.

Top module: `seq_shiftadd_mul`

## Requirements
- R1: After reset, `busy_o` is 0, `done_o` is 0 and `product_o` is 0.
- R2: A start in idle with both operands non-zero raises `busy_o` in the next cycle.
- R3: A start in idle with either operand equal to 0 gives `done_o`=1 and `product_o`=0 in the next cycle, and `busy_o` stays 0.
- R4: When `done_o` is high, `product_o` equals the full unsigned product of the operands captured at start, with width A_W+B_W. For example, 255 x 255 gives 65025.
- R5: With non-zero operands, `busy_o` is high for exactly k consecutive cycles, where k is one plus the index of the highest set bit of the first operand. An operand of 1 gives 1 cycle, and an operand with bit 7 set gives 8 cycles. The value of the second operand does not change k.
- R6: `done_o` is high in the cycle right after the last busy cycle. It lasts one cycle unless a new zero-operand start follows at once, and it is never high together with `busy_o`.
- R7: `product_o` keeps its value from completion until the next accepted start.
- R8: A start asserted while `busy_o` is high is ignored. The running product, its latency and the operands in use are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a multiplication; sampled only when idle |
| op_a_i | input | A_W | First operand (multiplier), captured at start |
| op_b_i | input | B_W | Second operand (multiplicand), captured at start |
| busy_o | output | 1 | High while steps are executing |
| done_o | output | 1 | One-cycle pulse when the product is valid |
| product_o | output | A_W+B_W | Accumulated product, held until the next start |

## Verification
The bench builds the block with its default 8-bit operand widths. At that size every latency from one to eight steps can be reached, and a random pool of operands quickly lands on each highest-bit position. The full-scale case 255 x 255 shows that the top accumulator bit is produced without a lost carry. Zero on either side, an operand of 1 and starts injected during a run are driven directly, so the early-exit and ignore paths are checked against a product and step count that the bench computes itself.

// File: rtl/smul_pkg.sv
package smul_pkg;

    typedef enum logic [0:0] {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } smul_phase_e;

endpackage

// File: rtl/smul_step.sv
// One shift-and-add step, purely combinational.
module smul_step #(
    parameter int A_W = 8,
    parameter int P_W = 16
) (
    input  logic [A_W-1:0] mplier_i,
    input  logic [P_W-1:0] mcand_i,
    input  logic [P_W-1:0] acc_i,
    output logic [A_W-1:0] mplier_o,
    output logic [P_W-1:0] mcand_o,
    output logic [P_W-1:0] acc_o,
    output logic           carry_o,
    output logic           last_o
);

    logic [P_W:0] sum_w;

    always_comb begin
        mplier_o = mplier_i >> 1;
        mcand_o  = mcand_i << 1;
        sum_w    = {1'b0, acc_i} + {1'b0, mcand_i};
        if (mplier_i[0]) begin
            acc_o   = sum_w[P_W-1:0];
            carry_o = sum_w[P_W];
        end else begin
            acc_o   = acc_i;
            carry_o = 1'b0;
        end
        last_o = (mplier_o == '0);
    end

endmodule

// File: rtl/smul_ctrl.sv
// Sequencer: idle / run phases plus the done pulse.
module smul_ctrl
    import smul_pkg::*;
#(
    parameter int A_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic a_zero_i,
    input  logic b_zero_i,
    input  logic last_i,
    output logic load_o,
    output logic step_o,
    output logic busy_o,
    output logic done_o
);

    localparam int CNT_W = $clog2(A_W + 1);

    typedef struct packed {
        smul_phase_e phase;
        logic        done;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d      = ctrl_q;
        ctrl_d.done = 1'b0;
        load_o      = 1'b0;
        step_o      = 1'b0;
        case (ctrl_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    load_o = 1'b1;
                    if (a_zero_i || b_zero_i) begin
                        ctrl_d.done = 1'b1;
                    end else begin
                        ctrl_d.phase = PH_RUN;
                    end
                end
            end
            PH_RUN: begin
                step_o = 1'b1;
                if (last_i) begin
                    ctrl_d.phase = PH_IDLE;
                    ctrl_d.done  = 1'b1;
                end
            end
            default: ctrl_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '{phase: PH_IDLE, done: 1'b0};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign busy_o = (ctrl_q.phase == PH_RUN);
    assign done_o = ctrl_q.done;

    // Busy-run length observer used only by the step-bound assertion.
    logic [CNT_W-1:0] run_len_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_len_q <= '0;
        end else if (busy_o) begin
            run_len_q <= run_len_q + CNT_W'(1);
        end else begin
            run_len_q <= '0;
        end
    end

    assert_step_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (run_len_q < CNT_W'(A_W)));

    assert_done_not_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> !done_o);

    assert_zero_quick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && (a_zero_i || b_zero_i)) |=> (done_o && !busy_o));

    assert_run_begins_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && !a_zero_i && !b_zero_i) |=> busy_o);

endmodule

// File: rtl/smul_datapath.sv
// Operand shift registers and the accumulator.
module smul_datapath #(
    parameter int A_W = 8,
    parameter int B_W = 8,
    parameter int P_W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load_i,
    input  logic           step_i,
    input  logic [A_W-1:0] op_a_i,
    input  logic [B_W-1:0] op_b_i,
    input  logic [A_W-1:0] mplier_nx_i,
    input  logic [P_W-1:0] mcand_nx_i,
    input  logic [P_W-1:0] acc_nx_i,
    input  logic           carry_i,
    input  logic           last_i,
    output logic [A_W-1:0] mplier_o,
    output logic [P_W-1:0] mcand_o,
    output logic [P_W-1:0] acc_o
);

    typedef struct packed {
        logic [A_W-1:0] mplier;
        logic [P_W-1:0] mcand;
        logic [P_W-1:0] acc;
    } dp_t;

    dp_t dp_d, dp_q;

    always_comb begin
        dp_d = dp_q;
        if (load_i) begin
            dp_d.mplier = op_a_i;
            dp_d.mcand  = {{(P_W-B_W){1'b0}}, op_b_i};
            dp_d.acc    = '0;
        end else if (step_i) begin
            dp_d.mplier = mplier_nx_i;
            dp_d.acc    = acc_nx_i;
            if (!last_i) begin
                dp_d.mcand = mcand_nx_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dp_q <= '0;
        end else begin
            dp_q <= dp_d;
        end
    end

    assign mplier_o = dp_q.mplier;
    assign mcand_o  = dp_q.mcand;
    assign acc_o    = dp_q.acc;

    assert_acc_no_carry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |-> !carry_i);

endmodule

// File: rtl/seq_shiftadd_mul.sv
module seq_shiftadd_mul #(
    parameter int A_W = 8,
    parameter int B_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [A_W-1:0]       op_a_i,
    input  logic [B_W-1:0]       op_b_i,
    output logic                 busy_o,
    output logic                 done_o,
    output logic [A_W+B_W-1:0]   product_o
);

    localparam int P_W = A_W + B_W;

    logic           load_w, step_w, last_w, carry_w;
    logic [A_W-1:0] mplier_w, mplier_nx_w;
    logic [P_W-1:0] mcand_w, mcand_nx_w, acc_w, acc_nx_w;
    logic           a_zero_w, b_zero_w;

    assign a_zero_w = (op_a_i == '0);
    assign b_zero_w = (op_b_i == '0);

    smul_ctrl #(.A_W(A_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .a_zero_i (a_zero_w),
        .b_zero_i (b_zero_w),
        .last_i   (last_w),
        .load_o   (load_w),
        .step_o   (step_w),
        .busy_o   (busy_o),
        .done_o   (done_o)
    );

    smul_step #(.A_W(A_W), .P_W(P_W)) u_step (
        .mplier_i (mplier_w),
        .mcand_i  (mcand_w),
        .acc_i    (acc_w),
        .mplier_o (mplier_nx_w),
        .mcand_o  (mcand_nx_w),
        .acc_o    (acc_nx_w),
        .carry_o  (carry_w),
        .last_o   (last_w)
    );

    smul_datapath #(.A_W(A_W), .B_W(B_W), .P_W(P_W)) u_dp (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load_w),
        .step_i      (step_w),
        .op_a_i      (op_a_i),
        .op_b_i      (op_b_i),
        .mplier_nx_i (mplier_nx_w),
        .mcand_nx_i  (mcand_nx_w),
        .acc_nx_i    (acc_nx_w),
        .carry_i     (carry_w),
        .last_i      (last_w),
        .mplier_o    (mplier_w),
        .mcand_o     (mcand_w),
        .acc_o       (acc_w)
    );

    assign product_o = acc_w;

    assert_product_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(product_o));

endmodule

// File: tb/sim_seq_shiftadd_mul.sv
module sim_seq_shiftadd_mul;

    localparam int A_W = 8;
    localparam int B_W = 8;
    localparam int P_W = A_W + B_W;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start_i = 1'b0;
    logic [A_W-1:0] op_a_i = '0;
    logic [B_W-1:0] op_b_i = '0;
    logic           busy_o, done_o;
    logic [P_W-1:0] product_o;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    seq_shiftadd_mul #(.A_W(A_W), .B_W(B_W)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_a_i(op_a_i),
        .op_b_i(op_b_i), .busy_o(busy_o), .done_o(done_o), .product_o(product_o)
    );

    function automatic int exp_steps(input logic [A_W-1:0] a);
        for (int i = A_W - 1; i >= 0; i--) begin
            if (a[i]) return i + 1;
        end
        return 0;
    endfunction

    function automatic logic [P_W-1:0] exp_prod(input logic [A_W-1:0] a, input logic [B_W-1:0] b);
        return P_W'(a) * P_W'(b);
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // One transaction; inject=1 pulses extra starts with other operands mid-run (R8).
    task automatic run_op(input logic [A_W-1:0] a, input logic [B_W-1:0] b, input bit inject);
        int busy_cnt = 0;
        int guard = 0;
        int ks = exp_steps(a);
        logic [P_W-1:0] ep = exp_prod(a, b);
        bit zero = (a == 0) || (b == 0);
        @(negedge clk);
        op_a_i = a; op_b_i = b; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (zero) begin
            check(done_o && !busy_o, "R3 done/busy", {done_o, busy_o}, 2);
        end else begin
            check(busy_o, "R2 busy after start", busy_o, 1);
        end
        while (!done_o && guard < 40) begin
            if (busy_o) busy_cnt++;
            if (inject) begin
                start_i = 1'b1;
                op_a_i = ~a; op_b_i = $urandom();
            end
            @(negedge clk);
            start_i = 1'b0;
            guard++;
        end
        start_i = 1'b0;
        check(done_o, "R6 done seen", done_o, 1);
        check(!busy_o, "R6 busy low with done", busy_o, 0);
        check(busy_cnt == (zero ? 0 : ks), inject ? "R8 latency with start while busy" : "R5 busy cycles",
              busy_cnt, zero ? 0 : ks);
        check(product_o == ep, inject ? "R8 product with start while busy" : "R4 product", product_o, ep);
        @(negedge clk);
        check(!done_o, "R6 done single pulse", done_o, 0);
        op_a_i = $urandom(); op_b_i = $urandom();
        @(negedge clk);
        check(product_o == ep, "R7 product held", product_o, ep);
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd1234);
        #1;
        check(!busy_o && !done_o && product_o == 0, "R1 reset state", {busy_o, done_o, product_o}, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check(!busy_o && !done_o && product_o == 0, "R1 after reset release", {busy_o, done_o, product_o}, 0);

        run_op(8'd7, 8'd9, 1'b0);
        run_op(8'd255, 8'd255, 1'b0);   // R4 full scale
        run_op(8'd0, 8'd200, 1'b0);     // R3
        run_op(8'd13, 8'd0, 1'b0);      // R3
        run_op(8'd0, 8'd0, 1'b0);       // R3
        run_op(8'd1, 8'd255, 1'b0);     // R5 one step
        run_op(8'd128, 8'd1, 1'b0);     // R5 eight steps
        run_op(8'd128, 8'd255, 1'b0);   // R5 b has no effect on latency
        run_op(8'd200, 8'd77, 1'b1);    // R8
        for (int i = 0; i < 8; i++) run_op(A_W'(1 << i), 8'd3, 1'b0);
        for (int i = 0; i < 1500; i++) begin
            logic [A_W-1:0] ra = $urandom();
            logic [B_W-1:0] rb = $urandom();
            if (($urandom() % 16) == 0) ra = 0;
            run_op(ra, rb, ($urandom() % 8) == 0);
        end

        // Back-to-back zero starts: done may stay high (R6 allowance), product 0 (R3).
        @(negedge clk);
        op_a_i = 0; op_b_i = 5; start_i = 1'b1;
        @(negedge clk);
        op_a_i = 9; op_b_i = 0;
        @(negedge clk);
        start_i = 1'b0;
        check(done_o && product_o == 0 && !busy_o, "R3 repeated zero start", product_o, 0);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 10);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule